// File: doc/BRIEF.md
# Bank-Switched Expansion RAM Controller

This block manages a 16 KB RAM card that sits over the top 12 KB of a 16-bit, 8-bit-data processor address space (0xD000 to 0xFFFF). A group of sixteen soft-switch locations at 0xC080 to 0xC08F sets the card's mode. Both bus reads and bus writes of those locations change it. The mode consists of a RAM-read flag, a RAM-write flag, a bank choice for the 4 KB window at 0xD000, and a small counter that arms writing.

On each access to the card range, the block drives the chip select, write strobe and 14-bit address of an external RAM. When the card is not supplying reads, it drives a ROM select instead and routes the ROM byte onto the returned read data. Writes reach the RAM only when writing has been armed. Arming takes two successive reads of odd switch locations, and any write to a switch disarms the counter.

The outputs are combinational from the current bus address and the registered mode. A switch access takes effect from the next clock edge.

Top module: `bank_ram_card`

## Requirements
- R1: An access counts as a switch access when busAddr[15:4] is 0xC08. Address bit 2 carries no meaning. No other address changes the card mode. Outside the card range (below 0xD000, including the switch window), ramCs, ramWe and romSel are 0 and rdData is 0.
- R2: Every switch access latches address bit 3 as the bank choice. When bit 3 is 1, the first 4 KB bank is visible at 0xD000–0xDFFF. When bit 3 is 0, the second bank is visible there. The region 0xE000–0xFFFF is the same under both choices.
- R3: A switch read with low bits 00 turns RAM reads on, turns RAM writes off and clears the arming counter.
- R4: A switch read with low bits 01 turns RAM reads off and advances the arming counter. The read that brings the counter to 2 turns RAM writes on. A single such read alone does not.
- R5: A switch read with low bits 10 turns both RAM reads and RAM writes off and clears the counter.
- R6: A switch read with low bits 11 turns RAM reads on and advances the arming counter under the same rule as R4.
- R7: A switch write always clears the counter and never turns RAM writes on. The effect depends on the low bits:
  - 00 turns reads on and writes off.
  - 01 turns reads off.
  - 10 turns both reads and writes off.
  - 11 turns reads on.
  - When writes are not turned off, their state is kept.
- R8: A read in 0xD000–0xFFFF while RAM reads are off asserts romSel, leaves ramCs at 0 and returns romData on rdData.
- R9: A read in 0xD000–0xFFFF while RAM reads are on asserts ramCs, leaves romSel at 0 and returns ramRdata on rdData.
- R10: A write in 0xD000–0xFFFF asserts both ramCs and ramWe only while RAM writes are on, whatever the RAM-read state.
- R11: The RAM address depends on the region:
  - The first bank maps to 0x0000–0x0FFF.
  - The second bank maps to 0x1000–0x1FFF.
  - 0xE000–0xFFFF maps to 0x2000–0x3FFF, as busAddr minus 0xC000.
- R12: After reset, RAM reads are off, RAM writes are off and the arming counter is 0.
- R13: The arming counter saturates at 2. Further odd switch reads keep writes on. Once the counter has been cleared, two fresh odd reads are needed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Processor address |
| busRead | input | 1 | Read access this cycle |
| busWrite | input | 1 | Write access this cycle (wins if both set) |
| busWdata | input | 8 | Processor write data |
| romData | input | 8 | Byte from the ROM under the card |
| ramRdata | input | 8 | Byte from the card RAM |
| rdData | output | 8 | Read data returned to the processor |
| romSel | output | 1 | ROM serves this read |
| ramCs | output | 1 | Card RAM chip select |
| ramWe | output | 1 | Card RAM write strobe |
| ramAddr | output | 14 | Card RAM byte address |
| ramWdata | output | 8 | Card RAM write data |

## Verification
The bench targets the arming rule. A single odd read followed by a RAM write must leave the RAM untouched; a design that arms on the first read would strobe ramWe there. A switch write placed between two odd reads must force a third read before writes land; a design that lets writes count toward arming, or does not clear the counter on them, would write early. It also reads the 0xF800 area and the 0xD000 bank with reads off, expecting ROM data, so a design that limited ROM fallback to the top 2 KB or swapped the bank polarity gives the wrong byte or address. Ignored bit 2, out-of-window addresses and writes with reads off are checked at the RAM strobes.

// File: rtl/bank_ram_pkg.sv
package bank_ram_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  // Mode state handed from control to datapath
  typedef struct packed {
    logic readEn;
    logic writeEn;
    logic bankFirst;
  } cardMode_t;

  // Meaning of the two low switch address bits
  typedef enum logic [1:0] {
    SW_READ_ON  = 2'b00,
    SW_ARM_ROFF = 2'b01,
    SW_ALL_OFF  = 2'b10,
    SW_ARM_RON  = 2'b11
  } swCode_t;
endpackage

// File: rtl/bank_ram_ctrl.sv
module bank_ram_ctrl
  import bank_ram_pkg::*;
#(
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hC080,
  parameter int ARM_COUNT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  output cardMode_t         mode
);
  localparam int CNT_W = $clog2(ARM_COUNT + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(ARM_COUNT);
  localparam logic [ADDR_W-1:0] WIN_MASK = ~ADDR_W'(15);

  logic [CNT_W-1:0] armCnt, cntNext, cntInc;
  cardMode_t modeNext;
  logic winHit;
  swCode_t code;

  assign winHit = ((busAddr & WIN_MASK) == WIN_BASE) && (busRead || busWrite);
  assign code   = swCode_t'(busAddr[1:0]);
  assign cntInc = (armCnt == CNT_TOP) ? armCnt : armCnt + 1'b1;

  always_comb begin
    modeNext = mode;
    cntNext  = armCnt;
    if (winHit) begin
      modeNext.bankFirst = busAddr[3];
      if (busWrite) begin
        cntNext = '0;
        unique case (code)
          SW_READ_ON:  begin modeNext.readEn = 1'b1; modeNext.writeEn = 1'b0; end
          SW_ARM_ROFF: modeNext.readEn = 1'b0;
          SW_ALL_OFF:  begin modeNext.readEn = 1'b0; modeNext.writeEn = 1'b0; end
          SW_ARM_RON:  modeNext.readEn = 1'b1;
        endcase
      end else begin
        unique case (code)
          SW_READ_ON: begin
            cntNext = '0; modeNext.readEn = 1'b1; modeNext.writeEn = 1'b0;
          end
          SW_ALL_OFF: begin
            cntNext = '0; modeNext.readEn = 1'b0; modeNext.writeEn = 1'b0;
          end
          SW_ARM_ROFF, SW_ARM_RON: begin
            cntNext = cntInc;
            modeNext.readEn = (code == SW_ARM_RON);
            if (cntInc >= CNT_TOP) modeNext.writeEn = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode   <= '0;
      armCnt <= '0;
    end else begin
      mode   <= modeNext;
      armCnt <= cntNext;
    end
  end

  // R1: non-switch cycles leave the mode alone
  a_r1_outside_stable: assert property (@(posedge clk) disable iff (!rstN)
    !winHit |=> mode == $past(mode));
  // R7: a switch write clears the counter and cannot raise write enable
  a_r7_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    winHit && busWrite |=> armCnt == '0 && (!mode.writeEn || $past(mode.writeEn)));
  // R3 / R5: even switch reads disarm
  a_r3_even_read_disarms: assert property (@(posedge clk) disable iff (!rstN)
    winHit && !busWrite && !busAddr[0] |=> !mode.writeEn && armCnt == '0);
  // R4: write enable only rises after the counter had reached one short of the limit
  a_r4_arm_needs_two: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mode.writeEn) |-> $past(armCnt) >= CNT_TOP - 1'b1);
  // R13: counter never passes its limit
  a_r13_cnt_saturates: assert property (@(posedge clk) disable iff (!rstN)
    armCnt <= CNT_TOP);
endmodule

// File: rtl/bank_ram_dpath.sv
module bank_ram_dpath
  import bank_ram_pkg::*;
#(
  parameter int BANK_AW = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] romData,
  input  logic [DATA_W-1:0] ramRdata,
  input  cardMode_t         mode,
  output logic [DATA_W-1:0] rdData,
  output logic              romSel,
  output logic              ramCs,
  output logic              ramWe,
  output logic [BANK_AW+1:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata
);
  localparam int TOP_BITS = ADDR_W - BANK_AW;

  logic inBanked, inCommon, inCard, isRead;

  assign inBanked = busAddr[ADDR_W-1 -: TOP_BITS] == TOP_BITS'(4'hD);
  assign inCommon = &busAddr[ADDR_W-1 -: TOP_BITS-1];
  assign inCard   = inBanked || inCommon;
  assign isRead   = busRead && !busWrite;

  always_comb begin
    if (inBanked) ramAddr = {1'b0, ~mode.bankFirst, busAddr[BANK_AW-1:0]};
    else          ramAddr = {1'b1, busAddr[BANK_AW:0]};
  end

  assign ramWe    = inCard && busWrite && mode.writeEn;
  assign ramCs    = ramWe || (inCard && isRead && mode.readEn);
  assign romSel   = inCard && isRead && !mode.readEn;
  assign ramWdata = busWdata;

  always_comb begin
    if (inCard && isRead) rdData = mode.readEn ? ramRdata : romData;
    else                  rdData = '0;
  end

  // R10: strobe only for armed writes
  a_r10_we_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> mode.writeEn && busWrite && ramCs);
  // R8: ROM path excludes the RAM and carries ROM data
  a_r8_rom_path: assert property (@(posedge clk) disable iff (!rstN)
    romSel |-> !ramCs && rdData == romData && busRead);
  // R9: RAM read path carries RAM data
  a_r9_ram_read: assert property (@(posedge clk) disable iff (!rstN)
    ramCs && !ramWe |-> rdData == ramRdata && !romSel);
endmodule

// File: rtl/bank_ram_card.sv
module bank_ram_card
  import bank_ram_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] busAddr,
  input  logic        busRead,
  input  logic        busWrite,
  input  logic [7:0]  busWdata,
  input  logic [7:0]  romData,
  input  logic [7:0]  ramRdata,
  output logic [7:0]  rdData,
  output logic        romSel,
  output logic        ramCs,
  output logic        ramWe,
  output logic [13:0] ramAddr,
  output logic [7:0]  ramWdata
);
  cardMode_t mode;

  bank_ram_ctrl #(.WIN_BASE(16'hC080), .ARM_COUNT(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr),
    .busRead(busRead), .busWrite(busWrite), .mode(mode)
  );

  bank_ram_dpath #(.BANK_AW(12)) u_dpath (
    .clk(clk), .rstN(rstN), .busAddr(busAddr),
    .busRead(busRead), .busWrite(busWrite), .busWdata(busWdata),
    .romData(romData), .ramRdata(ramRdata), .mode(mode),
    .rdData(rdData), .romSel(romSel), .ramCs(ramCs), .ramWe(ramWe),
    .ramAddr(ramAddr), .ramWdata(ramWdata)
  );
endmodule

// File: tb/bank_ram_card_bench.sv
`timescale 1ns/1ps
module bank_ram_card_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic busRead = 1'b0, busWrite = 1'b0;
  logic [7:0] busWdata = '0, romData = '0, ramRdata = '0;
  logic [7:0] rdData, ramWdata;
  logic romSel, ramCs, ramWe;
  logic [13:0] ramAddr;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bank_ram_card u_bank_ram_card (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRead(busRead),
    .busWrite(busWrite), .busWdata(busWdata), .romData(romData),
    .ramRdata(ramRdata), .rdData(rdData), .romSel(romSel), .ramCs(ramCs),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata)
  );

  typedef struct {
    logic cs; logic we; logic rom; logic [13:0] addr; logic [7:0] data; string req;
  } exp_t;
  exp_t scb[$];

  // reference mode, kept from the requirements
  bit mRe = 0, mWe = 0, mBankFirst = 0;
  int mCnt = 0;

  task automatic access(input logic [15:0] a, input bit wr, input string req);
    exp_t e;
    bit inCard;
    @(negedge clk);
    busAddr = a; busRead = !wr; busWrite = wr;
    busWdata = a[7:0] ^ 8'h5A; romData = 8'h3C ^ a[7:0]; ramRdata = 8'hA5 ^ a[15:8] ^ a[3:0];
    inCard = a[15:12] >= 4'hD;
    e.req  = req;
    e.cs   = inCard && (wr ? mWe : mRe);
    e.we   = inCard && wr && mWe;
    e.rom  = inCard && !wr && !mRe;
    e.data = (inCard && !wr) ? (mRe ? ramRdata : romData) : 8'h00;
    if (a[15:12] == 4'hD) e.addr = (mBankFirst ? 14'h0000 : 14'h1000) + 14'(a[11:0]);
    else                  e.addr = 14'(a - 16'hC000);
    scb.push_back(e);
    if (a[15:4] == 12'hC08) begin
      mBankFirst = a[3];
      if (wr) begin
        mCnt = 0;
        case (a[1:0])
          2'b00: begin mRe = 1; mWe = 0; end
          2'b01: mRe = 0;
          2'b10: begin mRe = 0; mWe = 0; end
          default: mRe = 1;
        endcase
      end else if (!a[0]) begin
        mCnt = 0; mWe = 0; mRe = !a[1];
      end else begin
        mCnt = (mCnt >= 2) ? 2 : mCnt + 1;
        mRe = a[1];
        if (mCnt >= 2) mWe = 1;
      end
    end
  endtask

  // monitor: compares before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (scb.size() > 0) begin
        exp_t e;
        e = scb.pop_front();
        checks++;
        if (ramCs !== e.cs || ramWe !== e.we || romSel !== e.rom || rdData !== e.data ||
            (e.cs && ramAddr !== e.addr)) begin
          failures++;
          $display("FAIL %s addr=%h: got cs=%b we=%b rom=%b ra=%h rd=%h exp cs=%b we=%b rom=%b ra=%h rd=%h",
                   e.req, busAddr, ramCs, ramWe, romSel, ramAddr, rdData,
                   e.cs, e.we, e.rom, e.addr, e.data);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R12: reset state
    access(16'hFFFC, 0, "R12 reset rom read");
    access(16'hE123, 1, "R12 reset write blocked");
    access(16'hD100, 0, "R12 reset banked rom read");
    // R6: one odd read is not enough
    access(16'hC08B, 0, "R6 first odd read");
    access(16'hD010, 1, "R4 single odd read no write");
    access(16'hD010, 0, "R9 ram read on");
    access(16'hC08B, 0, "R6 second odd read");
    access(16'hD010, 1, "R11 first bank write");
    // R2: bank swap keeps arming (R13 saturation)
    access(16'hC083, 0, "R13 third odd read");
    access(16'hD234, 1, "R2 second bank write");
    access(16'hD234, 0, "R2 second bank read");
    access(16'hE000, 1, "R11 common low");
    access(16'hFFFF, 0, "R11 common top");
    // R3
    access(16'hC080, 0, "R3 read 00");
    access(16'hE000, 1, "R3 writes off");
    access(16'hF800, 0, "R3 reads on");
    // R4 with bit 2 set (R1 ignored bit)
    access(16'hC085, 0, "R4 odd read bit2");
    access(16'hF900, 0, "R8 rom at F900");
    access(16'hC081, 0, "R4 second odd read");
    access(16'hF900, 1, "R10 write with reads off");
    access(16'hD800, 0, "R8 rom in banked area");
    // R5
    access(16'hC08E, 0, "R5 read 10");
    access(16'hD000, 1, "R5 writes off");
    access(16'hD000, 0, "R5 reads off");
    // R7: switch writes
    access(16'hC081, 0, "R7 odd read one");
    access(16'hC081, 1, "R7 write 01 clears count");
    access(16'hC081, 0, "R7 odd read after write");
    access(16'hD000, 1, "R7 not armed after write");
    access(16'hC081, 0, "R7 odd read completes");
    access(16'hD000, 1, "R7 armed");
    access(16'hC08C, 1, "R7 write 00");
    access(16'hE000, 1, "R7 write 00 disarmed");
    access(16'hE004, 0, "R7 write 00 reads on");
    access(16'hC08B, 1, "R7 write 11");
    access(16'hE008, 1, "R7 write 11 never arms");
    access(16'hC083, 0, "R7 rearm one");
    access(16'hC083, 0, "R7 rearm two");
    access(16'hC08B, 1, "R7 write 11 keeps write");
    access(16'hE00C, 1, "R7 write kept");
    access(16'hC089, 1, "R7 write 01");
    access(16'hE010, 0, "R7 write 01 reads off");
    access(16'hE010, 1, "R7 write 01 keeps write");
    access(16'hC08A, 1, "R7 write 10");
    access(16'hE014, 1, "R7 write 10 writes off");
    // R1: outside the window
    access(16'hC081, 0, "R1 odd read");
    access(16'hC090, 0, "R1 above window");
    access(16'hC07F, 0, "R1 below window");
    access(16'hC081, 0, "R1 count kept");
    access(16'hC091, 1, "R1 write outside");
    access(16'hD020, 1, "R1 armed after outside");
    access(16'hD020, 0, "R1 reads still off");
    @(negedge clk);
    busRead = 0; busWrite = 0; busAddr = '0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule